// File: doc/BRIEF.md
# Shared Time Base with Per-Context Compare Interrupts

This block keeps one free-running 64-bit time base that every processor context in the system can read. Software reaches it through a simple word-wide register bus. The count is exposed as two 32-bit words. A read of the lower word also captures the upper word into a holding register. A following read of the upper word returns that captured value, so software assembles a consistent 64-bit time even when a carry ripples between the two reads. A configuration word lets software freeze the count. The same word reports the block's fixed build parameters.

Each context owns a 64-bit compare value, a local pending word and a local enable mask. When the time base equals a context's compare value, the compare source of that context becomes pending. It stays pending until software writes either half of the compare value. Each context's enable mask has six source positions, and software changes it only through a set port and a clear port, where a 1 bit acts and a 0 bit does nothing. The context's interrupt output is raised whenever a source is both pending and enabled. Only the compare source has a pending input in this block. The other five mask positions are kept for neighbouring sources.

The shared words sit in the page at address 0x0000. Context `c` has its own page at address `0x8000 + c*0x100`.

Top module: `gcount_cmp`

## Requirements
- R1: When not frozen, the time base advances by exactly one on every clock, starting from the `CNT_RST` value after reset. Reading shared offset 0x10 returns its lower 32 bits as they stood at the clock edge that accepted the read.
- R2: While bit 28 of the configuration word (shared offset 0x00) is 1, the time base keeps its value. From the edge after that bit returns to 0, counting resumes from the held value. The bit resets to 0 and reads back at bit 28.
- R3: A read of shared offset 0x10 captures the upper 32 bits of the time base at that same edge. A read of shared offset 0x14 returns the captured value, not the live upper word, so a lower read followed by an upper read is never torn by a carry.
- R4: The configuration word reads bits 27:24 as CNT_W/4-8 (8 for 64 bits), bits 23:16 as NSRC_CAP-1, and bits 7:0 as NCTX-1. All other bits except bit 28 read 0, and writes never change any of these fields.
- R5: Each context's compare value is read and written at local offsets 0xA0 (lower word) and 0xA4 (upper word), and resets to all ones.
- R6: Bit 1 of a context's pending word becomes 1 on the edge where the time base equals that context's compare value. It stays 1 until a write to either compare half clears it, and that write takes priority over a match in the same cycle.
- R7: The pending word is read at local offset 0x04. Bits 0 and 2 to 5, and all bits above bit 5, always read 0.
- R8: A write to local offset 0x10 sets every mask bit whose written bit is 1. A write to local offset 0x0C clears every mask bit whose written bit is 1. Written 0 bits leave the mask unchanged. The 6-bit mask reads at local offset 0x08 and resets to 0.
- R9: `ctx_irq[c]` is 1 exactly when some bit position is 1 in both context c's pending word and its mask.
- R10: Accesses to one context's page never change the compare value, pending word or mask of any other context.
- R11: Every read is answered on the cycle after the read strobe, with `bus_rvalid` high for exactly that cycle. Unmapped offsets and context pages at or above NCTX return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 16 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| ctx_irq | output | NCTX | Per-context local interrupt |

## Verification
The hardest case to reach is a torn 64-bit read. The lower word must be read exactly when it holds 0xFFFFFFFF, so that the upper-word read in the next cycle falls after the carry. From reset a 64-bit counter never gets near that point. The bench therefore builds the block with a reset value just below a 32-bit boundary, keeps its own model of the count, and waits cycle by cycle until that model shows all ones in the lower word before it issues the lower read. The compare match is an equality that holds for a single cycle. The stimulus places the target a fixed distance ahead of the modelled count, then checks the pending bit both before and after that point and again much later to show that it persists.

// File: rtl/gcc_pkg.sv
// Package: shared constants for the shared time base and its per-context
// compare logic. Holds the word offsets that software decodes and the
// position of the compare source in the local pending and mask words.
package gcc_pkg;
    localparam int CNT_W   = 64;
    localparam int WORD_W  = 32;
    localparam int NLSRC   = 6;   // local source positions per context
    localparam int CMP_BIT = 1;   // compare source position in local words

    localparam int CFG_STOP_BIT = 28;

    // shared page offsets
    localparam logic [7:0] OFS_CFG    = 8'h00;
    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;

    // per-context page offsets
    localparam logic [7:0] OFS_LPEND  = 8'h04;
    localparam logic [7:0] OFS_LMASK  = 8'h08;
    localparam logic [7:0] OFS_LCLR   = 8'h0C;
    localparam logic [7:0] OFS_LSET   = 8'h10;
    localparam logic [7:0] OFS_CMP_LO = 8'hA0;
    localparam logic [7:0] OFS_CMP_HI = 8'hA4;

    // write strobes delivered to one context
    typedef struct packed {
        logic cmp_lo;
        logic cmp_hi;
        logic mask_set;
        logic mask_clr;
    } ctx_wr_t;
endpackage

// File: rtl/gcc_counter.sv
// Module: gcc_counter
// Free-running time base. Advances by one each clock unless hold is 1.
// Assumes: synchronous active-low reset loads RST_VAL.
module gcc_counter
    import gcc_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    output logic [CNT_W-1:0] count
);

    // Count up, or keep the value while held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= RST_VAL;
        else if (!hold)
            count <= count + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> count == $past(count) + 1'b1);  // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(count));  // R2

endmodule

// File: rtl/gcc_ctx.sv
// Module: gcc_ctx
// One processor context: 64-bit compare value, compare pending bit, a
// six-position enable mask with set and clear ports, and the local
// interrupt. Assumes at most one write strobe is active per cycle.
module gcc_ctx
    import gcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  ctx_wr_t           wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [NLSRC-1:0]  pend_vec,
    output logic [NLSRC-1:0]  mask_q,
    output logic              irq
);

    logic cmp_pend;
    logic cmp_touch;
    logic hit;

    assign cmp_touch = wr.cmp_lo | wr.cmp_hi;
    assign hit       = (count == cmp_q);

    // Compare value: each half written separately, resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else begin
            if (wr.cmp_lo)
                cmp_q[WORD_W-1:0] <= wdata;
            if (wr.cmp_hi)
                cmp_q[CNT_W-1:WORD_W] <= wdata;
        end
    end

    // Compare pending: set on equality, cleared by any compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_pend <= 1'b0;
        else if (cmp_touch)
            cmp_pend <= 1'b0;
        else if (hit)
            cmp_pend <= 1'b1;
    end

    // Enable mask: ones set through one port, ones clear through the other.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr.mask_set)
            mask_q <= mask_q | wdata[NLSRC-1:0];
        else if (wr.mask_clr)
            mask_q <= mask_q & ~wdata[NLSRC-1:0];
    end

    // Pending word: only the compare position has a source here.
    always_comb begin
        pend_vec          = '0;
        pend_vec[CMP_BIT] = cmp_pend;
    end

    // Local interrupt: any source that is both pending and enabled.
    assign irq = |(pend_vec & mask_q);

    AST_PEND_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmp_touch) |=> cmp_pend);  // R6
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_touch |=> !cmp_pend);  // R6
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pend && !cmp_touch) |=> cmp_pend);  // R6
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr.mask_set |=> (mask_q & $past(wdata[NLSRC-1:0])) == $past(wdata[NLSRC-1:0]));  // R8
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.mask_clr && !wr.mask_set) |=> (mask_q & $past(wdata[NLSRC-1:0])) == '0);  // R8
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.mask_clr && !wr.mask_set) |=> $stable(mask_q));  // R8

endmodule

// File: rtl/gcount_cmp.sv
// Module: gcount_cmp (top)
// Shared time base with a coherent two-word read, a freeze control,
// read-only build fields, and NCTX per-context compare units, all reached
// through a one-cycle register bus. Shared page at 0x0000, context c page
// at 0x8000 + c*0x100. Assumes 1 <= NCTX <= 16 and one access per cycle.
module gcount_cmp
    import gcc_pkg::*;
#(
    parameter int               NCTX     = 4,
    parameter int               NSRC_CAP = 24,
    parameter logic [CNT_W-1:0] CNT_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [NCTX-1:0]   ctx_irq
);

    localparam logic [3:0] WIDTH_CODE = 4'(CNT_W / 4 - 8);
    localparam logic [7:0] SRC_FIELD  = 8'(NSRC_CAP - 1);
    localparam logic [7:0] CTX_FIELD  = 8'(NCTX - 1);
    localparam int         HI_W       = CNT_W - WORD_W;

    logic [7:0]        ofs;
    logic              sh_hit;
    logic              lc_hit;
    logic [3:0]        ctx_sel;
    logic              stop_q;
    logic [HI_W-1:0]   shadow_q;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] cfg_word;
    logic [WORD_W-1:0] rd_mux;

    logic [CNT_W-1:0]  cmp_arr  [NCTX];
    logic [NLSRC-1:0]  pend_arr [NCTX];
    logic [NLSRC-1:0]  mask_arr [NCTX];

    // Address split into page and word offset.
    assign ofs     = bus_addr[7:0];
    assign sh_hit  = (bus_addr[15:8] == 8'h00);
    assign lc_hit  = (bus_addr[15:12] == 4'h8);
    assign ctx_sel = bus_addr[11:8];

    // Freeze control, the only writable configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_q <= 1'b0;
        else if (bus_wr && sh_hit && ofs == OFS_CFG)
            stop_q <= bus_wdata[CFG_STOP_BIT];
    end

    // Upper-word capture on every lower-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (bus_rd && sh_hit && ofs == OFS_CNT_LO)
            shadow_q <= count[CNT_W-1:WORD_W];
    end

    gcc_counter #(
        .RST_VAL (CNT_RST)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (stop_q),
        .count (count)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        ctx_wr_t wr_c;
        logic    pick;

        assign pick           = bus_wr && lc_hit && (ctx_sel == 4'(c));
        assign wr_c.cmp_lo    = pick && (ofs == OFS_CMP_LO);
        assign wr_c.cmp_hi    = pick && (ofs == OFS_CMP_HI);
        assign wr_c.mask_set  = pick && (ofs == OFS_LSET);
        assign wr_c.mask_clr  = pick && (ofs == OFS_LCLR);

        gcc_ctx u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .count    (count),
            .wr       (wr_c),
            .wdata    (bus_wdata),
            .cmp_q    (cmp_arr[c]),
            .pend_vec (pend_arr[c]),
            .mask_q   (mask_arr[c]),
            .irq      (ctx_irq[c])
        );
    end

    // Configuration word: freeze bit plus fixed build fields.
    always_comb begin
        cfg_word               = '0;
        cfg_word[CFG_STOP_BIT] = stop_q;
        cfg_word[27:24]        = WIDTH_CODE;
        cfg_word[23:16]        = SRC_FIELD;
        cfg_word[7:0]          = CTX_FIELD;
    end

    // Read select across the shared page and the addressed context page.
    always_comb begin
        rd_mux = '0;
        if (sh_hit) begin
            case (ofs)
                OFS_CFG:    rd_mux = cfg_word;
                OFS_CNT_LO: rd_mux = count[WORD_W-1:0];
                OFS_CNT_HI: rd_mux = WORD_W'(shadow_q);
                default:    rd_mux = '0;
            endcase
        end else if (lc_hit) begin
            for (int c = 0; c < NCTX; c++) begin
                if (ctx_sel == 4'(c)) begin
                    case (ofs)
                        OFS_LPEND:  rd_mux = WORD_W'(pend_arr[c]);
                        OFS_LMASK:  rd_mux = WORD_W'(mask_arr[c]);
                        OFS_CMP_LO: rd_mux = cmp_arr[c][WORD_W-1:0];
                        OFS_CMP_HI: rd_mux = cmp_arr[c][CNT_W-1:WORD_W];
                        default:    rd_mux = '0;
                    endcase
                end
            end
        end
    end

    // Registered read response, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd)
                bus_rdata <= rd_mux;
        end
    end

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);  // R11
    AST_RVALID_ONLY_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);  // R11
    AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && sh_hit && ofs == OFS_CNT_LO) |=> $stable(shadow_q));  // R3

endmodule

// File: tb/gcount_cmp_bench.sv
`timescale 1ns/1ps
module gcount_cmp_bench;
    localparam int          NCTX = 4;
    localparam logic [63:0] RSTV = 64'h0000_0005_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NCTX-1:0] ctx_irq;

    typedef struct {
        logic [31:0] exp;
        string       req;
        logic [15:0] addr;
    } sb_item_t;
    sb_item_t sb_q[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] mcnt;
    logic        mstop;
    logic [31:0] mshadow = '0;
    logic [63:0] tgt;

    localparam logic [31:0] CFG_BASE = {4'h0, 4'h8, 8'd23, 8'h00, 8'd3};

    always #2 clk = ~clk;

    gcount_cmp #(.NCTX(NCTX), .NSRC_CAP(24), .CNT_RST(RSTV)) u_gcount_cmp (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ctx_irq(ctx_irq)
    );

    // Reference model of the time base, built from R1 and R2.
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt  <= RSTV;
            mstop <= 1'b0;
        end else begin
            if (!mstop) mcnt <= mcnt + 64'd1;
            if (bus_wr && bus_addr == 16'h0000) mstop <= bus_wdata[28];
        end
    end

    // Monitor: pop the expected item for each read response and compare.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    // All tasks start and end at a falling edge.
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string req);
        sb_item_t it;
        it.exp = e; it.req = req; it.addr = a;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_lo(input string req);
        mshadow = mcnt[63:32];
        bus_read(16'h0010, mcnt[31:0], req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_irq(input logic [NCTX-1:0] e, input string req);
        n_chk++;
        if (ctx_irq !== e) begin
            n_fail++;
            $display("FAIL %s ctx_irq actual=%b expected=%b", req, ctx_irq, e);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // reset state
        check_irq('0, "R9 reset");
        n_chk++;
        if (bus_rvalid !== 1'b0) begin
            n_fail++; $display("FAIL R11 rvalid after reset actual=%b expected=0", bus_rvalid);
        end
        bus_read(16'h8008, 32'h0, "R8 mask reset");
        bus_read(16'h80A0, 32'hFFFF_FFFF, "R5 compare reset lo");
        bus_read(16'h80A4, 32'hFFFF_FFFF, "R5 compare reset hi");
        bus_read(16'h0000, CFG_BASE, "R4 config reset");

        // R1: stepping by one
        rd_lo("R1");
        idle(7);
        rd_lo("R1");
        bus_read(16'h0014, mshadow, "R3 upper after lower");

        // R3: lower read exactly at all ones, upper read after the carry
        while (mcnt[31:0] != 32'hFFFF_FFFF) @(negedge clk);
        rd_lo("R3 carry lo");
        bus_read(16'h0014, 32'h0000_0005, "R3 carry hi torn");
        rd_lo("R3 after carry lo");
        bus_read(16'h0014, 32'h0000_0006, "R3 after carry hi");
        idle(3);
        bus_read(16'h0014, 32'h0000_0006, "R3 upper without new lower");

        // R2: freeze and resume
        bus_write(16'h0000, 32'h1000_0000);
        rd_lo("R2 frozen");
        idle(5);
        rd_lo("R2 still frozen");
        bus_read(16'h0000, CFG_BASE | 32'h1000_0000, "R2 stop bit readback");
        bus_write(16'h0000, 32'hFFFF_FFFF);
        bus_read(16'h0000, CFG_BASE | 32'h1000_0000, "R4 read-only fields");
        bus_write(16'h0000, 32'h0);
        idle(3);
        rd_lo("R2 resumed");
        bus_read(16'h0000, CFG_BASE, "R4 config after clear");

        // R5 and R10: context 1 compare value far ahead
        bus_write(16'h81A0, 32'h1234_5678);
        bus_write(16'h81A4, 32'hFFFF_0000);
        bus_read(16'h81A0, 32'h1234_5678, "R5 ctx1 lo");
        bus_read(16'h81A4, 32'hFFFF_0000, "R5 ctx1 hi");
        bus_read(16'h80A4, 32'hFFFF_FFFF, "R10 ctx0 compare untouched");

        // R6: context 0 match
        tgt = mcnt + 64'd60;
        bus_write(16'h80A0, tgt[31:0]);
        bus_write(16'h80A4, tgt[63:32]);
        bus_read(16'h8004, 32'h0, "R6 not yet pending");
        idle(70);
        bus_read(16'h8004, 32'h0000_0002, "R6 R7 pending after match");
        check_irq('0, "R9 pending but masked");
        bus_read(16'h8104, 32'h0, "R10 ctx1 not pending");
        idle(20);
        bus_read(16'h8004, 32'h0000_0002, "R6 pending persists");

        // R8 and R9: mask set and clear ports
        bus_write(16'h8010, 32'h0);
        bus_read(16'h8008, 32'h0, "R8 set with zeros");
        check_irq('0, "R9 still masked");
        bus_write(16'h8010, 32'h0000_0002);
        bus_read(16'h8008, 32'h0000_0002, "R8 set bit1");
        check_irq(4'b0001, "R9 enabled and pending");
        bus_write(16'h800C, 32'h0);
        bus_read(16'h8008, 32'h0000_0002, "R8 clear with zeros");
        bus_write(16'h8010, 32'h0000_0021);
        bus_read(16'h8008, 32'h0000_0023, "R8 set more bits");
        bus_write(16'h800C, 32'h0000_0002);
        bus_read(16'h8008, 32'h0000_0021, "R8 clear bit1");
        check_irq('0, "R9 compare disabled");
        bus_read(16'h8208, 32'h0, "R10 ctx2 mask untouched");
        check_irq('0, "R10 other contexts quiet");

        // R6: compare write clears pending
        bus_write(16'h8010, 32'h0000_0002);
        check_irq(4'b0001, "R9 enabled again");
        bus_write(16'h80A4, tgt[63:32]);
        bus_read(16'h8004, 32'h0, "R6 cleared by compare write");
        check_irq('0, "R9 after clear");

        // R11: unmapped reads
        bus_read(16'h0040, 32'h0, "R11 unmapped shared");
        bus_read(16'h8F08, 32'h0, "R11 context beyond NCTX");
        bus_read(16'h80B0, 32'h0, "R11 unmapped local");

        idle(3);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing responses actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule